// File: doc/BRIEF.md
# Relay Operate and Reset Time Analyzer

This block measures how long a protective relay takes to react to an injected fault. A test sequencer raises a one-cycle fault-start pulse when the fault is applied and a one-cycle fault-clear pulse when it is removed. Eight contact inputs from the relay under test arrive asynchronously. Each input is synchronized, then debounced by a qualification filter that counts 1 µs ticks. The block reports the time from fault start to the first qualified closure of a selected contact (operate time). It also reports the time from fault clear to the first qualified opening of that contact (reset time).

Every finished trial produces a one-cycle result strobe with the measured time, its kind and a no-trip flag. A no-trip result means the selected contact did not respond within a programmable timeout. Tripped results from many repeated trials feed a separate set of statistics for each kind: trial count, minimum, maximum and a 48-bit running sum. The host derives mean times from these values. The host clears all statistics with a single command.

Top module: `relay_time_analyzer`

## Requirements
- R1: During reset every count, sum, maximum and timestamp reads zero, each minimum reads all ones, and the result strobe is low.
- R2: `now_us` is a free-running timestamp that advances by exactly one every TICK_DIV clock cycles (one 1 µs tick).
- R3: Each contact input is synchronized by two flops. A change is accepted only after the synchronized input has differed from the accepted level on `qual_ticks` consecutive ticks (a value of 0 acts as 1). Shorter pulses produce no result.
- R4: A `fault_start` pulse arms an operate trial. The next accepted 0-to-1 change on channel `chan_sel` ends it with `res_kind`=0 and `res_time` equal to the ticks elapsed since the pulse.
- R5: A `fault_clear` pulse arms a reset trial. The next accepted 1-to-0 change on channel `chan_sel` ends it with `res_kind`=1 and the elapsed ticks.
- R6: When the elapsed ticks of an armed trial reach `timeout_ticks` before a matching edge, the trial ends with `res_notrip`=1 and `res_time` equal to `timeout_ticks`. The statistics are left unchanged.
- R7: Only the first accepted edge after a marker ends a trial. Later edges, bounces, and edges on unselected channels produce no result until the next marker.
- R8: A tripped result adds one to the count of its kind, adds its time to that kind's 48-bit sum, and lowers the minimum or raises the maximum when exceeded. The updated values appear in the same cycle as the result strobe.
- R9: `stats_clr` returns all statistics to their reset values. It takes priority over an update in the same cycle.
- R10: A marker that arrives while a trial is armed abandons that trial with no result and starts a new one timed from the new marker.
- R11: `res_valid` is high for exactly one cycle per finished trial. `res_kind`, `res_notrip` and `res_time` hold their values until the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| contact_in | input | CH | Asynchronous relay contact inputs |
| fault_start | input | 1 | One-cycle pulse marking fault application |
| fault_clear | input | 1 | One-cycle pulse marking fault removal |
| chan_sel | input | log2(CH) | Contact channel being timed |
| qual_ticks | input | QUAL_W | Stable ticks needed to accept a contact change |
| timeout_ticks | input | TS_W | No-trip limit in ticks |
| stats_clr | input | 1 | Clears all statistics |
| now_us | output | TS_W | Free-running 1 µs timestamp |
| res_valid | output | 1 | One-cycle result strobe |
| res_kind | output | 1 | 0 operate, 1 reset |
| res_notrip | output | 1 | Trial timed out |
| res_time | output | TS_W | Measured ticks |
| op_count | output | CNT_W | Tripped operate trials |
| op_min | output | TS_W | Shortest operate time |
| op_max | output | TS_W | Longest operate time |
| op_sum | output | SUM_W | Sum of operate times |
| rs_count | output | CNT_W | Tripped reset trials |
| rs_min | output | TS_W | Shortest reset time |
| rs_max | output | TS_W | Longest reset time |
| rs_sum | output | SUM_W | Sum of reset times |

## Verification
The hardest case to reach from the ports is a contact edge that arrives while the block is idle or waiting on another channel. Such an edge looks exactly like a valid trip, yet it must leave both the result strobe and the statistics untouched. The stimulus produces this case in three ways. It drives a long, fully qualified bounce after a trip has been recorded. It closes an unselected contact while an operate trial is armed. It applies a glitch one tick shorter than the qualification window, followed by a timeout. A cycle-level model tracks every output throughout, so any stray update shows up at the cycle where it happens.

// File: rtl/relay_time_analyzer.sv
module relay_time_analyzer #(
  parameter int CH       = 8,
  parameter int TS_W     = 32,
  parameter int SUM_W    = 48,
  parameter int CNT_W    = 16,
  parameter int QUAL_W   = 8,
  parameter int TICK_DIV = 250,
  localparam int SEL_W   = $clog2(CH),
  localparam int DIV_W   = $clog2(TICK_DIV + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CH-1:0]     contact_in,
  input  logic              fault_start,
  input  logic              fault_clear,
  input  logic [SEL_W-1:0]  chan_sel,
  input  logic [QUAL_W-1:0] qual_ticks,
  input  logic [TS_W-1:0]   timeout_ticks,
  input  logic              stats_clr,
  output logic [TS_W-1:0]   now_us,
  output logic              res_valid,
  output logic              res_kind,
  output logic              res_notrip,
  output logic [TS_W-1:0]   res_time,
  output logic [CNT_W-1:0]  op_count,
  output logic [TS_W-1:0]   op_min,
  output logic [TS_W-1:0]   op_max,
  output logic [SUM_W-1:0]  op_sum,
  output logic [CNT_W-1:0]  rs_count,
  output logic [TS_W-1:0]   rs_min,
  output logic [TS_W-1:0]   rs_max,
  output logic [SUM_W-1:0]  rs_sum
);

  typedef enum logic [1:0] {IDLE, WAIT_OP, WAIT_RS} state_t;

  logic [DIV_W-1:0] div_q;
  logic             tick;
  assign tick = (div_q == DIV_W'(TICK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_q  <= '0;
      now_us <= '0;
    end else begin
      div_q <= tick ? '0 : div_q + 1'b1;
      if (tick) now_us <= now_us + 1'b1;
    end

  logic [CH-1:0] s1_q, s2_q, filt, acc;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= contact_in;
      s2_q <= s1_q;
    end

  logic [QUAL_W-1:0] qlim;
  assign qlim = (qual_ticks == '0) ? '0 : qual_ticks - 1'b1;

  for (genvar g = 0; g < CH; g++) begin : g_qual
    logic [QUAL_W-1:0] run_q;
    logic              f_q;
    assign filt[g] = f_q;
    assign acc[g]  = tick && (s2_q[g] != f_q) && (run_q >= qlim);
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        run_q <= '0;
        f_q   <= 1'b0;
      end else if (s2_q[g] == f_q) begin
        run_q <= '0;
      end else if (acc[g]) begin
        f_q   <= s2_q[g];
        run_q <= '0;
      end else if (tick) begin
        run_q <= run_q + 1'b1;
      end
  end

  state_t           st_q;
  logic [TS_W-1:0]  mark_q, elapsed;
  logic             hit_rise, hit_fall, fin, fin_nt, fin_kind;

  assign elapsed  = now_us - mark_q;
  assign hit_rise = acc[chan_sel] &  s2_q[chan_sel];
  assign hit_fall = acc[chan_sel] & ~s2_q[chan_sel];
  assign fin_kind = (st_q == WAIT_RS);

  always_comb begin
    fin    = 1'b0;
    fin_nt = 1'b0;
    if (!fault_start && !fault_clear) begin
      if (st_q == WAIT_OP && hit_rise)      fin = 1'b1;
      else if (st_q == WAIT_RS && hit_fall) fin = 1'b1;
      else if (st_q != IDLE && elapsed >= timeout_ticks) begin
        fin    = 1'b1;
        fin_nt = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st_q       <= IDLE;
      mark_q     <= '0;
      res_valid  <= 1'b0;
      res_kind   <= 1'b0;
      res_notrip <= 1'b0;
      res_time   <= '0;
    end else begin
      res_valid <= fin;
      if (fin) begin
        res_kind   <= fin_kind;
        res_notrip <= fin_nt;
        res_time   <= elapsed;
      end
      if (fault_start) begin
        st_q   <= WAIT_OP;
        mark_q <= now_us;
      end else if (fault_clear) begin
        st_q   <= WAIT_RS;
        mark_q <= now_us;
      end else if (fin) begin
        st_q <= IDLE;
      end
    end

  for (genvar k = 0; k < 2; k++) begin : g_stat
    logic [CNT_W-1:0] c_q;
    logic [TS_W-1:0]  mn_q, mx_q;
    logic [SUM_W-1:0] s_q;
    logic             upd;
    assign upd = fin && !fin_nt && (fin_kind == 1'(k));
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        c_q  <= '0;
        mn_q <= '1;
        mx_q <= '0;
        s_q  <= '0;
      end else if (stats_clr) begin
        c_q  <= '0;
        mn_q <= '1;
        mx_q <= '0;
        s_q  <= '0;
      end else if (upd) begin
        c_q <= c_q + 1'b1;
        s_q <= s_q + SUM_W'(elapsed);
        if (elapsed < mn_q) mn_q <= elapsed;
        if (elapsed > mx_q) mx_q <= elapsed;
      end
  end

  assign op_count = g_stat[0].c_q;
  assign op_min   = g_stat[0].mn_q;
  assign op_max   = g_stat[0].mx_q;
  assign op_sum   = g_stat[0].s_q;
  assign rs_count = g_stat[1].c_q;
  assign rs_min   = g_stat[1].mn_q;
  assign rs_max   = g_stat[1].mx_q;
  assign rs_sum   = g_stat[1].s_q;

endmodule

// File: rtl/relay_time_analyzer_chk.sv
module relay_time_analyzer_chk #(
  parameter int TS_W  = 32,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stats_clr,
  input logic [TS_W-1:0]  timeout_ticks,
  input logic [TS_W-1:0]  now_us,
  input logic             res_valid,
  input logic             res_kind,
  input logic             res_notrip,
  input logic [TS_W-1:0]  res_time,
  input logic [CNT_W-1:0] op_count,
  input logic [TS_W-1:0]  op_min,
  input logic [TS_W-1:0]  op_max,
  input logic [CNT_W-1:0] rs_count
);

  // R11
  strobe_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R2
  ts_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (now_us == $past(now_us)) || (now_us == $past(now_us) + 1'b1));

  // R8
  op_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_notrip && !res_kind && !$past(stats_clr)
      |-> op_count == $past(op_count) + 1'b1);

  // R8
  min_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_count != '0) |-> (op_min <= op_max));

  // R6
  notrip_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_notrip |-> res_time >= $past(timeout_ticks));

  // R6
  notrip_stats_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_notrip && !$past(stats_clr)
      |-> (op_count == $past(op_count)) && (rs_count == $past(rs_count)));

endmodule

bind relay_time_analyzer relay_time_analyzer_chk #(.TS_W(TS_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/test_relay_time_analyzer.sv
module test_relay_time_analyzer;
  localparam int TD = 4;

  logic        clk = 0, rst_n = 0;
  logic [7:0]  cin = 0;
  logic        fs = 0, fc = 0, clr = 0;
  logic [2:0]  sel = 3'd2;
  logic [7:0]  qual = 8'd3;
  logic [31:0] tmo = 32'd60;
  logic [31:0] now_us, res_time, op_min, op_max, rs_min, rs_max;
  logic        res_valid, res_kind, res_notrip;
  logic [15:0] op_count, rs_count;
  logic [47:0] op_sum, rs_sum;

  always #2 clk = ~clk;

  relay_time_analyzer #(.TICK_DIV(TD)) i_relay_time_analyzer (
    .clk(clk), .rst_n(rst_n), .contact_in(cin), .fault_start(fs), .fault_clear(fc),
    .chan_sel(sel), .qual_ticks(qual), .timeout_ticks(tmo), .stats_clr(clr),
    .now_us(now_us), .res_valid(res_valid), .res_kind(res_kind), .res_notrip(res_notrip),
    .res_time(res_time), .op_count(op_count), .op_min(op_min), .op_max(op_max),
    .op_sum(op_sum), .rs_count(rs_count), .rs_min(rs_min), .rs_max(rs_max), .rs_sum(rs_sum));

  int ntests = 0, nfail = 0;
  bit done = 0;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    ntests++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference, one step per clock
  bit          live = 0;
  int          md, mst, mrun[8];
  bit [31:0]   mts, mmark, mtime, mmin[2], mmax[2];
  bit [7:0]    q1, q2, mf;
  bit          mv, mk, mnt;
  int          mc[2];
  longint      ms[2];

  always @(posedge clk) begin
    if (!rst_n) begin
      md = 0; mst = 0; mts = 0; mmark = 0; mtime = 0; q1 = 0; q2 = 0; mf = 0;
      mv = 0; mk = 0; mnt = 0;
      foreach (mrun[c]) mrun[c] = 0;
      for (int k = 0; k < 2; k++) begin mc[k] = 0; ms[k] = 0; mmin[k] = '1; mmax[k] = 0; end
    end else begin
      bit tk, fin, nt, kd;
      bit [7:0] ac;
      bit [31:0] el;
      int ql;
      live = 1;
      tk = (md == TD - 1);
      ql = (qual == 0) ? 0 : qual - 1;
      for (int c = 0; c < 8; c++) ac[c] = tk && (q2[c] != mf[c]) && (mrun[c] >= ql);
      el = mts - mmark;
      fin = 0; nt = 0; kd = (mst == 2);
      if (!fs && !fc) begin
        if (mst == 1 && ac[sel] && q2[sel]) fin = 1;
        else if (mst == 2 && ac[sel] && !q2[sel]) fin = 1;
        else if (mst != 0 && el >= tmo) begin fin = 1; nt = 1; end
      end
      mv = fin;
      if (fin) begin mk = kd; mnt = nt; mtime = el; end
      if (clr) begin
        for (int k = 0; k < 2; k++) begin mc[k] = 0; ms[k] = 0; mmin[k] = '1; mmax[k] = 0; end
      end else if (fin && !nt) begin
        mc[kd]++; ms[kd] += el;
        if (el < mmin[kd]) mmin[kd] = el;
        if (el > mmax[kd]) mmax[kd] = el;
      end
      if (fs) begin mst = 1; mmark = mts; end
      else if (fc) begin mst = 2; mmark = mts; end
      else if (fin) mst = 0;
      for (int c = 0; c < 8; c++) begin
        if (q2[c] == mf[c]) mrun[c] = 0;
        else if (ac[c]) begin mf[c] = q2[c]; mrun[c] = 0; end
        else if (tk) mrun[c]++;
      end
      q2 = q1; q1 = cin;
      if (tk) begin md = 0; mts++; end else md++;
    end
  end

  // per-cycle comparison and result monitor
  int        n_res = 0;
  bit        lk, lnt;
  bit [31:0] lt;
  bit [31:0] omin[2] = '{32'hffffffff, 32'hffffffff};
  bit [31:0] omax[2] = '{0, 0};
  longint    osum[2] = '{0, 0};

  always @(negedge clk) begin
    if (rst_n && live) begin
      chk(now_us == mts, "R2 now_us", now_us, mts);
      chk(res_valid == mv, "R11 res_valid", res_valid, mv);
      chk(res_kind == mk && res_notrip == mnt, "R4/R5 kind,notrip", {res_kind, res_notrip}, {mk, mnt});
      chk(res_time == mtime, mk ? "R5 res_time" : "R4 res_time", res_time, mtime);
      chk(op_count == mc[0] && rs_count == mc[1], "R8 counts", {op_count, rs_count}, {mc[0][15:0], mc[1][15:0]});
      chk(op_min == mmin[0] && rs_min == mmin[1], "R8 minima", {op_min, rs_min}, {mmin[0], mmin[1]});
      chk(op_max == mmax[0] && rs_max == mmax[1], "R8 maxima", {op_max, rs_max}, {mmax[0], mmax[1]});
      chk(op_sum == ms[0][47:0] && rs_sum == ms[1][47:0], "R8 sums", op_sum, ms[0]);
      if (res_valid) begin
        n_res++; lk = res_kind; lnt = res_notrip; lt = res_time;
        if (!res_notrip) begin
          osum[res_kind] += res_time;
          if (res_time < omin[res_kind]) omin[res_kind] = res_time;
          if (res_time > omax[res_kind]) omax[res_kind] = res_time;
        end
      end
    end
  end

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask
  task automatic p_start; @(negedge clk) fs = 1; @(negedge clk) fs = 0; endtask
  task automatic p_clear; @(negedge clk) fc = 1; @(negedge clk) fc = 0; endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int n0;
    cyc(5);
    // R1 reset state
    chk(now_us == 0 && res_valid == 0, "R1 now_us/res_valid", now_us, 0);
    chk(op_count == 0 && rs_count == 0 && op_sum == 0 && rs_sum == 0, "R1 counts/sums", op_count, 0);
    chk(op_min == 32'hffffffff && rs_min == 32'hffffffff && op_max == 0 && rs_max == 0,
        "R1 min/max", op_min, 32'hffffffff);
    rst_n = 1;
    cyc(10);

    // R4 R5 R8: many trials with varying delays on channel 2
    for (int i = 0; i < 120; i++) begin
      p_start(); cyc(8 + (i * 7) % 90);
      cin[2] = 1; cyc(30);
      p_clear(); cyc(5 + (i * 3) % 40);
      cin[2] = 0; cyc(30);
    end
    chk(op_count == 120, "R4 operate trial count", op_count, 120);
    chk(rs_count == 120, "R5 reset trial count", rs_count, 120);
    chk(op_min == omin[0] && op_max == omax[0], "R8 operate min/max vs results", op_min, omin[0]);
    chk(op_sum == osum[0][47:0], "R8 operate sum vs results", op_sum, osum[0]);
    chk(rs_min == omin[1] && rs_max == omax[1] && rs_sum == osum[1][47:0],
        "R8 reset stats vs results", rs_sum, osum[1]);

    // R7 other channel ignored, then bounces after the trip ignored
    p_start(); cyc(20);
    n0 = n_res; cin[5] = 1; cyc(40);
    chk(n_res == n0, "R7 unselected channel", n_res, n0);
    cin[2] = 1; cyc(40);
    chk(n_res == n0 + 1 && lk == 0 && lnt == 0, "R7 first edge result", n_res, n0 + 1);
    n0 = n_res;
    cin[2] = 0; cyc(40); cin[2] = 1; cyc(40);
    chk(n_res == n0 && op_count == 121, "R7 bounce ignored", op_count, 121);
    p_clear(); cin[2] = 0; cin[5] = 0; cyc(60);

    // R3 glitch shorter than qualification, then R6 timeout
    n0 = n_res;
    p_start(); cyc(10);
    cin[2] = 1; cyc(6); cin[2] = 0;
    cyc(300);
    chk(n_res == n0 + 1, "R3 glitch gives no result", n_res, n0 + 1);
    chk(lnt == 1 && lk == 0 && lt == 60, "R6 no-trip result time", lt, 60);
    chk(op_count == 121, "R6 no-trip leaves stats", op_count, 121);

    // R10 second marker restarts the trial
    n0 = n_res;
    p_start(); cyc(40); p_start(); cyc(20);
    cin[2] = 1; cyc(40);
    chk(n_res == n0 + 1, "R10 single result", n_res, n0 + 1);
    chk(lt <= 12, "R10 timed from second marker", lt, 12);
    p_clear(); cyc(10); cin[2] = 0; cyc(60);

    // R9 clear
    @(negedge clk) clr = 1; @(negedge clk) clr = 0;
    cyc(2);
    chk(op_count == 0 && rs_count == 0 && op_sum == 0 && rs_sum == 0, "R9 counts/sums cleared", op_count, 0);
    chk(op_min == 32'hffffffff && op_max == 0 && rs_min == 32'hffffffff && rs_max == 0,
        "R9 min/max cleared", op_min, 32'hffffffff);

    // R3 qualification of zero behaves as one tick
    qual = 0;
    p_start(); cyc(15); cin[2] = 1; cyc(20);
    chk(op_count == 1 && lnt == 0, "R3 qual zero accepted", op_count, 1);
    p_clear(); cyc(15); cin[2] = 0; cyc(20);
    chk(rs_count == 1 && lk == 1, "R5 reset after clear", rs_count, 1);
    cyc(10);
    finish_run();
  end
endmodule